// File: doc/BRIEF.md
# Three-Bus Microcoded Datapath

This block is the register-and-bus core of a microcoded processor. Each clock cycle it takes one wide control word, already split into fields at its ports. Two operand buses each pick one value. The choices are a zero, one of seven internal registers (A, B, TEMP, TEMP2, PC, MAR, MDR), an externally supplied constant or an externally supplied immediate. A small ALU combines the two operands onto a destination bus. That bus can load any mix of the C, TEMP, TEMP2, PC, MAR and MDR registers in the same cycle.

Memory is reached through a simple single-cycle port. MAR supplies the address and MDR supplies the write data. A read result can be captured into MDR, through a one-bit source mux, or into the instruction register. A 32-entry register file feeds the A and B latches and takes writes from C. Each of its three actions is gated by its own bit of a 3-bit control field.

All state changes on one rising clock edge, and every update uses the values held before that edge. The microsequencer, the constant generator and the immediate extractor sit outside the block.

Top module: `tribus_datapath`

## Requirements
- R1: Operand selector codes are the same for both buses: 0 zero, 1 A, 2 B, 3 TEMP, 4 TEMP2, 5 PC, 6 MAR, 7 MDR, 8 const_in, 9 imm_in; codes 10 to 15 drive zero.
- R2: ALU op codes: 1 add, 2 subtract (operand 1 minus operand 2), 3 AND, 4 OR, 5 pass operand 1. Codes 0, 6 and 7 stall: the destination bus is zero and both operand buses carry zero.
- R3: C, TEMP, TEMP2, PC and MAR each load the destination bus on the clock edge when their own write-enable is high, and hold otherwise.
- R4: When mdr_we is high, MDR loads the destination bus if mdr_src is 0. If mdr_src is 1, MDR loads mem_rdata only when a memory read is issued in that cycle, and holds otherwise.
- R5: mem_op 1 issues a read and mem_op 2 issues a write; 0 and 3 are idle. While an operation is issued, mem_busy is high, mem_addr equals MAR and mem_wdata equals MDR; mem_we is high only for a write.
- R6: IR, seen on ir_out, loads mem_rdata when ir_we is high and a read is issued in that cycle, and holds otherwise.
- R7: A loads register-file entry rf_addr_a only when a_we and rf_ctl bit 0 are both high. B loads entry rf_addr_b only when b_we and rf_ctl bit 1 are both high.
- R8: rf_ctl bit 2 writes C into entry rf_addr_c using C's value from before the edge. An A or B load on the same edge reads the entry's old content.
- R9: Synchronous reset clears A, B, C, TEMP, TEMP2, PC, MAR, MDR, IR and every register-file entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src1_sel | input | 4 | Operand bus 1 source code |
| src2_sel | input | 4 | Operand bus 2 source code |
| alu_op | input | 3 | ALU operation code |
| c_we | input | 1 | Load C from destination bus |
| tmp_we | input | 1 | Load TEMP from destination bus |
| tmp2_we | input | 1 | Load TEMP2 from destination bus |
| pc_we | input | 1 | Load PC from destination bus |
| mar_we | input | 1 | Load MAR from destination bus |
| mdr_we | input | 1 | Load MDR |
| mdr_src | input | 1 | MDR source: 0 destination bus, 1 memory read data |
| ir_we | input | 1 | Load IR from memory read data |
| a_we | input | 1 | A latch load enable |
| b_we | input | 1 | B latch load enable |
| rf_ctl | input | 3 | Register-file action bits: 0 read to A, 1 read to B, 2 write C |
| rf_addr_a | input | 5 | Register-file address for A |
| rf_addr_b | input | 5 | Register-file address for B |
| rf_addr_c | input | 5 | Register-file address for the C write |
| mem_op | input | 2 | Memory operation code |
| const_in | input | 32 | Constant operand |
| imm_in | input | 32 | Immediate operand |
| mem_rdata | input | 32 | Memory read data, valid in the cycle of a read |
| dest_bus | output | 32 | ALU result (destination bus) |
| ir_out | output | 32 | Instruction register |
| mem_busy | output | 1 | A memory operation is issued this cycle |
| mem_we | output | 1 | Issued operation is a write |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_wdata | output | 32 | Memory write data (MDR) |

## Verification
Every internal register can be read back through an operand bus, so a wrong register value shows on dest_bus in the first cycle that selects it with the pass operation. The registers that cannot be selected directly are C and the register-file entries. Their faults show two to three edges later, after the value has been moved into A. A faulty MAR or MDR also shows at once on mem_addr and mem_wdata, and a bad memory capture shows on ir_out or on the next MDR readout. The sweep drives every selector-and-operation combination against register contents that differ from one another, so a swapped code or a wrong operation gives a mismatch on dest_bus.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int SEL_W     = 4;
  localparam int ALUOP_W   = 3;
  localparam int MEMOP_W   = 2;
  localparam int RFCTL_W   = 3;
  localparam int SRC_SLOTS = 2 ** SEL_W;

  localparam logic [SEL_W-1:0] SRC_NONE  = 4'd0;
  localparam logic [SEL_W-1:0] SRC_A     = 4'd1;
  localparam logic [SEL_W-1:0] SRC_B     = 4'd2;
  localparam logic [SEL_W-1:0] SRC_TMP   = 4'd3;
  localparam logic [SEL_W-1:0] SRC_TMP2  = 4'd4;
  localparam logic [SEL_W-1:0] SRC_PC    = 4'd5;
  localparam logic [SEL_W-1:0] SRC_MAR   = 4'd6;
  localparam logic [SEL_W-1:0] SRC_MDR   = 4'd7;
  localparam logic [SEL_W-1:0] SRC_CONST = 4'd8;
  localparam logic [SEL_W-1:0] SRC_IMM   = 4'd9;

  localparam logic [ALUOP_W-1:0] ALU_STALL = 3'd0;
  localparam logic [ALUOP_W-1:0] ALU_ADD   = 3'd1;
  localparam logic [ALUOP_W-1:0] ALU_SUB   = 3'd2;
  localparam logic [ALUOP_W-1:0] ALU_AND   = 3'd3;
  localparam logic [ALUOP_W-1:0] ALU_OR    = 3'd4;
  localparam logic [ALUOP_W-1:0] ALU_PASS  = 3'd5;

  localparam logic [MEMOP_W-1:0] MEM_IDLE = 2'd0;
  localparam logic [MEMOP_W-1:0] MEM_RD   = 2'd1;
  localparam logic [MEMOP_W-1:0] MEM_WR   = 2'd2;

  localparam int RF_BIT_LDA = 0;
  localparam int RF_BIT_LDB = 1;
  localparam int RF_BIT_WRC = 2;

  function automatic logic alu_is_live(input logic [ALUOP_W-1:0] op);
    return (op >= ALU_ADD) && (op <= ALU_PASS);
  endfunction
endpackage

// File: rtl/tbd_src_mux.sv
module tbd_src_mux
  import tbd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SEL_W-1:0]                  sel,
  input  logic [SRC_SLOTS-1:0][DATA_W-1:0]  slots,
  output logic [DATA_W-1:0]                 bus
);
  // Every code has a slot; unused slots are tied to zero by the parent.
  assign bus = slots[sel];
endmodule

// File: rtl/tbd_alu.sv
module tbd_alu
  import tbd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [ALUOP_W-1:0] op,
  input  logic [DATA_W-1:0]  in1,
  input  logic [DATA_W-1:0]  in2,
  output logic [DATA_W-1:0]  res
);
  function automatic logic [DATA_W-1:0] alu_f(input logic [ALUOP_W-1:0] f,
                                               input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    case (f)
      ALU_ADD:  return x + y;
      ALU_SUB:  return x - y;
      ALU_AND:  return x & y;
      ALU_OR:   return x | y;
      ALU_PASS: return x;
      default:  return '0;
    endcase
  endfunction

  assign res = alu_f(op, in1, in2);
endmodule

// File: rtl/tbd_regfile.sv
module tbd_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  // Asynchronous read: loads on an edge see the pre-edge contents.
  assign rd_data_a = cells[rd_addr_a];
  assign rd_data_b = cells[rd_addr_b];
endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
  import tbd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RF_DEPTH = 32,
  localparam int RF_AW   = $clog2(RF_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   src1_sel,
  input  logic [SEL_W-1:0]   src2_sel,
  input  logic [ALUOP_W-1:0] alu_op,
  input  logic               c_we,
  input  logic               tmp_we,
  input  logic               tmp2_we,
  input  logic               pc_we,
  input  logic               mar_we,
  input  logic               mdr_we,
  input  logic               mdr_src,
  input  logic               ir_we,
  input  logic               a_we,
  input  logic               b_we,
  input  logic [RFCTL_W-1:0] rf_ctl,
  input  logic [RF_AW-1:0]   rf_addr_a,
  input  logic [RF_AW-1:0]   rf_addr_b,
  input  logic [RF_AW-1:0]   rf_addr_c,
  input  logic [MEMOP_W-1:0] mem_op,
  input  logic [DATA_W-1:0]  const_in,
  input  logic [DATA_W-1:0]  imm_in,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  dest_bus,
  output logic [DATA_W-1:0]  ir_out,
  output logic               mem_busy,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);
  localparam int NBUS = 2;

  logic [DATA_W-1:0] a_q, b_q, c_q, tmp_q, tmp2_q, pc_q, mar_q, mdr_q, ir_q;
  logic [DATA_W-1:0] rf_rd_a, rf_rd_b;

  // Named internal events, visible to the bound checker.
  logic alu_live;
  logic mem_rd_fire;
  logic mem_wr_fire;
  logic a_load, b_load, rf_wr;
  logic [DATA_W-1:0] op1_bus, op2_bus;

  assign alu_live    = alu_is_live(alu_op);
  assign mem_rd_fire = (mem_op == MEM_RD);
  assign mem_wr_fire = (mem_op == MEM_WR);
  assign a_load      = a_we & rf_ctl[RF_BIT_LDA];
  assign b_load      = b_we & rf_ctl[RF_BIT_LDB];
  assign rf_wr       = rf_ctl[RF_BIT_WRC];

  // Source slots: code N selects slot N; codes without a source stay zero.
  logic [SRC_SLOTS-1:0][DATA_W-1:0] slots;
  always_comb begin
    slots            = '0;
    slots[SRC_A]     = a_q;
    slots[SRC_B]     = b_q;
    slots[SRC_TMP]   = tmp_q;
    slots[SRC_TMP2]  = tmp2_q;
    slots[SRC_PC]    = pc_q;
    slots[SRC_MAR]   = mar_q;
    slots[SRC_MDR]   = mdr_q;
    slots[SRC_CONST] = const_in;
    slots[SRC_IMM]   = imm_in;
  end

  // A stalled ALU selects nothing on either bus.
  logic [NBUS-1:0][SEL_W-1:0]  sel_eff;
  logic [NBUS-1:0][DATA_W-1:0] opnd;
  assign sel_eff[0] = alu_live ? src1_sel : SRC_NONE;
  assign sel_eff[1] = alu_live ? src2_sel : SRC_NONE;

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    tbd_src_mux #(.DATA_W(DATA_W)) u_mux (
      .sel   (sel_eff[g]),
      .slots (slots),
      .bus   (opnd[g])
    );
  end
  assign op1_bus = opnd[0];
  assign op2_bus = opnd[1];

  tbd_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (alu_op),
    .in1 (op1_bus),
    .in2 (op2_bus),
    .res (dest_bus)
  );

  tbd_regfile #(.DATA_W(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (rf_wr),
    .wr_addr   (rf_addr_c),
    .wr_data   (c_q),
    .rd_addr_a (rf_addr_a),
    .rd_addr_b (rf_addr_b),
    .rd_data_a (rf_rd_a),
    .rd_data_b (rf_rd_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      tmp_q  <= '0;
      tmp2_q <= '0;
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
    end else begin
      if (c_we)    c_q    <= dest_bus;
      if (tmp_we)  tmp_q  <= dest_bus;
      if (tmp2_we) tmp2_q <= dest_bus;
      if (pc_we)   pc_q   <= dest_bus;
      if (mar_we)  mar_q  <= dest_bus;
      if (mdr_we) begin
        if (!mdr_src)         mdr_q <= dest_bus;
        else if (mem_rd_fire) mdr_q <= mem_rdata;
      end
      if (ir_we && mem_rd_fire) ir_q <= mem_rdata;
      if (a_load) a_q <= rf_rd_a;
      if (b_load) b_q <= rf_rd_b;
    end
  end

  assign ir_out    = ir_q;
  assign mem_busy  = mem_rd_fire | mem_wr_fire;
  assign mem_we    = mem_wr_fire;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker
  import tbd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [SEL_W-1:0]   src1_sel,
  input logic [ALUOP_W-1:0] alu_op,
  input logic [DATA_W-1:0]  dest_bus,
  input logic [DATA_W-1:0]  op1_bus,
  input logic [DATA_W-1:0]  op2_bus,
  input logic               mar_we,
  input logic [DATA_W-1:0]  mar_q,
  input logic               mdr_we,
  input logic               mdr_src,
  input logic [DATA_W-1:0]  mdr_q,
  input logic               ir_we,
  input logic [DATA_W-1:0]  ir_q,
  input logic [MEMOP_W-1:0] mem_op,
  input logic [DATA_W-1:0]  mem_rdata,
  input logic               mem_busy,
  input logic               mem_we,
  input logic               a_we,
  input logic [RFCTL_W-1:0] rf_ctl,
  input logic [DATA_W-1:0]  a_q
);
  assert_unused_code_R1: assert property (@(posedge clk) disable iff (rst)
    (src1_sel > 4'd9 || src1_sel == 4'd0) |-> op1_bus == '0);

  assert_stall_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 3'd0 || alu_op > 3'd5) |-> (dest_bus == '0 && op1_bus == '0 && op2_bus == '0));

  assert_mar_load_R3: assert property (@(posedge clk) disable iff (rst)
    mar_we |=> mar_q == $past(dest_bus));

  assert_mar_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !mar_we |=> $stable(mar_q));

  assert_mdr_dest_R4: assert property (@(posedge clk) disable iff (rst)
    (mdr_we && !mdr_src) |=> mdr_q == $past(dest_bus));

  assert_mdr_mem_R4: assert property (@(posedge clk) disable iff (rst)
    (mdr_we && mdr_src && mem_op == 2'd1) |=> mdr_q == $past(mem_rdata));

  assert_mdr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mdr_we && mdr_src && mem_op != 2'd1) |=> $stable(mdr_q));

  assert_busy_read_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 2'd1) |-> (mem_busy && !mem_we));

  assert_busy_write_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 2'd2) |-> (mem_busy && mem_we));

  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 2'd0 || mem_op == 2'd3) |-> (!mem_busy && !mem_we));

  assert_ir_load_R6: assert property (@(posedge clk) disable iff (rst)
    (ir_we && mem_op == 2'd1) |=> ir_q == $past(mem_rdata));

  assert_ir_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(ir_we && mem_op == 2'd1) |=> $stable(ir_q));

  assert_a_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !(a_we && rf_ctl[0]) |=> $stable(a_q));
endmodule

bind tribus_datapath tbd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src1_sel  (src1_sel),
  .alu_op    (alu_op),
  .dest_bus  (dest_bus),
  .op1_bus   (op1_bus),
  .op2_bus   (op2_bus),
  .mar_we    (mar_we),
  .mar_q     (mar_q),
  .mdr_we    (mdr_we),
  .mdr_src   (mdr_src),
  .mdr_q     (mdr_q),
  .ir_we     (ir_we),
  .ir_q      (ir_q),
  .mem_op    (mem_op),
  .mem_rdata (mem_rdata),
  .mem_busy  (mem_busy),
  .mem_we    (mem_we),
  .a_we      (a_we),
  .rf_ctl    (rf_ctl),
  .a_q       (a_q)
);

// File: tb/sim_tribus_datapath.sv
`timescale 1ns/100ps
module sim_tribus_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src1_sel, src2_sel;
  logic [2:0]  alu_op;
  logic        c_we, tmp_we, tmp2_we, pc_we, mar_we, mdr_we, mdr_src, ir_we, a_we, b_we;
  logic [2:0]  rf_ctl;
  logic [4:0]  rf_addr_a, rf_addr_b, rf_addr_c;
  logic [1:0]  mem_op;
  logic [31:0] const_in, imm_in, mem_rdata;
  logic [31:0] dest_bus, ir_out, mem_addr, mem_wdata;
  logic        mem_busy, mem_we;

  always #2 clk = ~clk;

  tribus_datapath u0 (
    .clk(clk), .rst(rst), .src1_sel(src1_sel), .src2_sel(src2_sel), .alu_op(alu_op),
    .c_we(c_we), .tmp_we(tmp_we), .tmp2_we(tmp2_we), .pc_we(pc_we), .mar_we(mar_we),
    .mdr_we(mdr_we), .mdr_src(mdr_src), .ir_we(ir_we), .a_we(a_we), .b_we(b_we),
    .rf_ctl(rf_ctl), .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b), .rf_addr_c(rf_addr_c),
    .mem_op(mem_op), .const_in(const_in), .imm_in(imm_in), .mem_rdata(mem_rdata),
    .dest_bus(dest_bus), .ir_out(ir_out), .mem_busy(mem_busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Bench memory: 16 words, combinational read, written by the bench model.
  logic [31:0] ram [16];
  assign mem_rdata = ram[mem_addr[3:0]];

  // Expected state, derived from the requirements.
  logic [31:0] mA, mB, mC, mT, mT2, mPC, mMAR, mMDR, mIR;
  logic [31:0] mRF [32];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_src(input logic [3:0] code);
    case (code)
      4'd1: return mA;
      4'd2: return mB;
      4'd3: return mT;
      4'd4: return mT2;
      4'd5: return mPC;
      4'd6: return mMAR;
      4'd7: return mMDR;
      4'd8: return const_in;
      4'd9: return imm_in;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_alu(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    case (op)
      3'd1: return x + y;
      3'd2: return x + (~y) + 32'd1;
      3'd3: return x & y;
      3'd4: return x | y;
      3'd5: return x;
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle();
    src1_sel = 0; src2_sel = 0; alu_op = 0;
    c_we = 0; tmp_we = 0; tmp2_we = 0; pc_we = 0; mar_we = 0;
    mdr_we = 0; mdr_src = 0; ir_we = 0; a_we = 0; b_we = 0;
    rf_ctl = 0; rf_addr_a = 0; rf_addr_b = 0; rf_addr_c = 0; mem_op = 0;
  endtask

  task automatic model_reset();
    mA = 0; mB = 0; mC = 0; mT = 0; mT2 = 0; mPC = 0; mMAR = 0; mMDR = 0; mIR = 0;
    for (int i = 0; i < 32; i++) mRF[i] = 0;
  endtask

  // One clock edge: expected next state from current inputs, then advance.
  task automatic tick();
    logic [31:0] d, rd, nA, nB, nC, nT, nT2, nPC, nMAR, nMDR, nIR;
    logic rd_go;
    d = (alu_op >= 3'd1 && alu_op <= 3'd5) ? exp_alu(alu_op, exp_src(src1_sel), exp_src(src2_sel)) : 32'h0;
    rd_go = (mem_op == 2'd1);
    rd = ram[mMAR[3:0]];
    nC = c_we ? d : mC;  nT = tmp_we ? d : mT;  nT2 = tmp2_we ? d : mT2;
    nPC = pc_we ? d : mPC;  nMAR = mar_we ? d : mMAR;
    nMDR = mMDR;
    if (mdr_we && !mdr_src) nMDR = d;
    if (mdr_we && mdr_src && rd_go) nMDR = rd;
    nIR = (ir_we && rd_go) ? rd : mIR;
    nA = (a_we && rf_ctl[0]) ? mRF[rf_addr_a] : mA;
    nB = (b_we && rf_ctl[1]) ? mRF[rf_addr_b] : mB;
    @(posedge clk);
    if (mem_op == 2'd2) ram[mMAR[3:0]] = mMDR;
    if (rf_ctl[2]) mRF[rf_addr_c] = mC;
    mA = nA; mB = nB; mC = nC; mT = nT; mT2 = nT2; mPC = nPC; mMAR = nMAR; mMDR = nMDR; mIR = nIR;
    #1;
  endtask

  // Observe each selectable register through operand bus 1 with pass.
  task automatic check_regs(input string tag);
    for (int k = 1; k <= 7; k++) begin
      idle(); src1_sel = 4'(k); alu_op = 3'd5;
      #0.5;
      chk($sformatf("%s sel%0d", tag, k), dest_bus, exp_src(4'(k)));
    end
    chk({tag, " ir"}, ir_out, mIR);
    idle();
  endtask

  // Load a constant into a register through the destination bus.
  task automatic load_const(input logic [31:0] v, input int which);
    idle(); const_in = v; src1_sel = 4'd8; alu_op = 3'd5;
    case (which)
      0: c_we = 1; 1: tmp_we = 1; 2: tmp2_we = 1; 3: pc_we = 1; 4: mar_we = 1; default: mdr_we = 1;
    endcase
    tick();
    idle();
  endtask

  // Move C into rf[addr] and then into A or B through the register file.
  task automatic rf_to(input logic [4:0] addr, input bit to_b);
    idle(); rf_ctl = 3'b100; rf_addr_c = addr; tick();
    idle();
    if (to_b) begin b_we = 1; rf_ctl = 3'b010; rf_addr_b = addr; end
    else      begin a_we = 1; rf_ctl = 3'b001; rf_addr_a = addr; end
    tick(); idle();
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = 32'hA500_0000 + 32'(i * 7);
    idle(); const_in = 32'h0; imm_in = 32'h0;
    model_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;

    // R9: reset state
    check_regs("R9 reset");
    chk("R9 reset busy", {31'h0, mem_busy}, 32'h0);

    // R3: load every destination-bus register with distinct values
    load_const(32'h1111_0001, 1);
    load_const(32'h2222_0002, 2);
    load_const(32'h3333_0003, 3);
    load_const(32'h0000_0004, 4);
    load_const(32'h5555_0005, 5);
    load_const(32'h6666_0006, 0);
    rf_to(5'd3, 0);
    load_const(32'h7777_0007, 0);
    rf_to(5'd31, 1);
    check_regs("R3 load");

    // R3: no enable -> hold
    idle(); const_in = 32'hDEAD_BEEF; src1_sel = 4'd8; alu_op = 3'd5; tick(); idle();
    check_regs("R3 hold");

    // R1 R2: sweep every selector pair and op code
    const_in = 32'h0F0F_1234; imm_in = 32'hF00D_8001;
    for (int s1 = 0; s1 < 16; s1++)
      for (int s2 = 0; s2 < 16; s2++)
        for (int op = 0; op < 8; op++) begin
          src1_sel = 4'(s1); src2_sel = 4'(s2); alu_op = 3'(op);
          #0.5;
          chk($sformatf("R1/R2 s1=%0d s2=%0d op=%0d", s1, s2, op), dest_bus,
              (op >= 1 && op <= 5) ? exp_alu(3'(op), exp_src(4'(s1)), exp_src(4'(s2))) : 32'h0);
        end
    idle();

    // R5: write issue, ports reflect MAR and MDR
    idle(); mem_op = 2'd2; #0.5;
    chk("R5 wr busy", {30'h0, mem_busy, mem_we}, 32'h3);
    chk("R5 wr addr", mem_addr, mMAR);
    chk("R5 wr data", mem_wdata, mMDR);
    tick(); idle();
    mem_op = 2'd3; #0.5;
    chk("R5 code3 idle", {30'h0, mem_busy, mem_we}, 32'h0);
    idle();
    load_const(32'h0BAD_0BAD, 5);

    // R4: memory source without a read issued -> hold
    idle(); mdr_we = 1; mdr_src = 1; tick(); idle();
    check_regs("R4 mdr hold");

    // R4 R6: read back the written word into MDR and IR
    idle(); mem_op = 2'd1; #0.5;
    chk("R5 rd busy", {30'h0, mem_busy, mem_we}, 32'h2);
    mdr_we = 1; mdr_src = 1; ir_we = 1; tick(); idle();
    chk("R4 mdr from mem", mMDR, 32'h5555_0005);
    check_regs("R4/R6 read");

    // R6: ir_we with a write issued -> hold
    idle(); load_const(32'h0000_0009, 4);
    idle(); ir_we = 1; mem_op = 2'd2; tick(); idle();
    check_regs("R6 ir hold");

    // R7: enable without rf bit, and rf bit without enable
    load_const(32'h4242_4242, 0);
    idle(); rf_ctl = 3'b100; rf_addr_c = 5'd8; tick();
    idle(); a_we = 1; rf_ctl = 3'b000; rf_addr_a = 5'd8; tick();
    idle(); rf_ctl = 3'b011; rf_addr_a = 5'd8; rf_addr_b = 5'd8; tick();
    idle(); b_we = 1; rf_ctl = 3'b001; rf_addr_b = 5'd8; tick(); idle();
    check_regs("R7 gate");
    idle(); b_we = 1; rf_ctl = 3'b010; rf_addr_b = 5'd8; tick(); idle();
    check_regs("R7 load");

    // R8: same-edge C load, rf write of old C, and A read of old entry
    load_const(32'hAAAA_0001, 0);
    idle(); rf_ctl = 3'b100; rf_addr_c = 5'd12; tick();
    idle(); const_in = 32'hBBBB_0002; src1_sel = 4'd8; alu_op = 3'd5; c_we = 1;
    rf_ctl = 3'b101; rf_addr_c = 5'd12; a_we = 1; rf_addr_a = 5'd12;
    tick(); idle();
    chk("R8 A old entry", mA, 32'hAAAA_0001);
    check_regs("R8 same edge");
    idle(); const_in = 32'hCCCC_0003; src1_sel = 4'd8; alu_op = 3'd5; c_we = 1;
    rf_ctl = 3'b100; rf_addr_c = 5'd20; tick(); idle();
    idle(); a_we = 1; rf_ctl = 3'b001; rf_addr_a = 5'd20; tick(); idle();
    chk("R8 old C stored", mA, 32'hBBBB_0002);
    check_regs("R8 readback");

    // R9: reset mid-run clears registers and register file
    rst = 1; tick(); model_reset(); rst = 0;
    check_regs("R9 mid reset");
    idle(); a_we = 1; b_we = 1; rf_ctl = 3'b011; rf_addr_a = 5'd3; rf_addr_b = 5'd31; tick(); idle();
    check_regs("R9 rf cleared");
    chk("R9 rf entry", mA, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule